// File: doc/BRIEF.md
# Three-Level Lane Operand File

This block holds the operands of one SIMT lane across three storage levels: a tiny last-result file, a small operand file, and the large main register file. The main file itself sits outside; this block only reaches it through a port. Each instruction's operands reach the block already decoded. The instruction encoding tells the block which level each operand lives in and which entry within that level, so there are no tags and no lookups. One issue cycle reads up to three source operands in parallel. The block also accepts one result per cycle and sends it to the levels its encoding names.

The two upper levels are shared over time among the active warp slots. The slot is part of the entry index, so each slot has its own entries. When the compiler marks the last instruction of a strand, every upper-level entry of that slot is dropped. A value that must outlive the strand therefore has to be in the main file. Only the private ALU may use the last-result file. The shared units (special function, memory, texture) may use only the operand file and the main file. A build-time switch gives each slot three last-result banks, one per operand position, in place of one shared entry.

Any access that breaks these rules is not performed, and it raises an error flag. So is any read of an entry that holds no valid value.

Top module: `ofh_lane_opfile`

## Requirements
- R1: After reset, `opnd_valid`, `opnd_err` and `wb_err` are 0, and every operand-file and last-result entry of every slot is empty.
- R2: In an issue cycle, source i uses the level code `src_lvl[2i+1:2i]`: 0 is unused (data 0), 1 is main (data is `mrf_rdata[32i+31:32i]`), 2 is operand file, 3 is last-result file. All three results appear together in `opnd_data[32i+31:32i]`, with `opnd_valid` high, in the cycle after issue.
- R3: Operand-file entries are addressed by {`issue_slot`, entry index `src_idx[2i+1:2i]`}, with 3 entries per slot. Writing an entry of one slot does not change any entry of another slot.
- R4: In the default build, the last-result file has exactly one entry per slot, and the index field of a last-result access is ignored.
- R5: A legal result with `wb_to_mrf` set drives `mrf_we` high, with `mrf_wdata` equal to `wb_data`, in the same cycle. It may also go to the operand file in that cycle.
- R6: A result with both `wb_orf` and `wb_lrf` set is dropped completely: no upper-level write and no `mrf_we`. `wb_err` is high in the next cycle.
- R7: A shared-unit access (`issue_shared` for reads, `wb_shared` for results) to the last-result file is refused. A refused read gives data 0 and its `opnd_err` bit. A refused result is dropped and raises `wb_err`. Shared units may still use the operand file and the main file.
- R8: An issue with `issue_strand_end` set empties every upper-level entry of `issue_slot` at the end of that cycle. Reads in that same cycle still see the old contents. A same-cycle result to that slot is not retained. Other slots keep their entries.
- R9: An operand-file or last-result read of an empty entry sets that source's `opnd_err` bit and returns data 0.
- R10: A read in the same cycle as a legal result write to the same entry returns the new result.
- R11: An operand-file index of 3 is refused. On a read it sets `opnd_err`; on a result it drops the result and raises `wb_err`.
- R12: With `SPLIT_LRF`=1, each slot has three last-result banks, selected by the index field (0, 1, 2) on both reads and writes. Index 3 is refused in the same way as in R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | An instruction reads its sources this cycle |
| issue_slot | input | 3 | Active warp slot of the issuing instruction |
| issue_shared | input | 1 | Issuing instruction runs on a shared unit |
| issue_strand_end | input | 1 | Issuing instruction ends its strand |
| src_lvl | input | 6 | Level code per source (2 bits each) |
| src_idx | input | 6 | Entry or bank index per source (2 bits each) |
| mrf_rdata | input | 96 | Main-file read data per source |
| wb_valid | input | 1 | A result arrives this cycle |
| wb_slot | input | 3 | Slot of the result |
| wb_shared | input | 1 | Result comes from a shared unit |
| wb_to_mrf | input | 1 | Result targets the main file |
| wb_orf | input | 1 | Result targets the operand file |
| wb_lrf | input | 1 | Result targets the last-result file |
| wb_idx | input | 2 | Entry or bank index of the result |
| wb_data | input | 32 | Result value |
| opnd_valid | output | 1 | Operand data valid (cycle after issue) |
| opnd_data | output | 96 | Three source operands |
| opnd_err | output | 3 | Per-source access error |
| wb_err | output | 1 | Previous cycle's result was refused |
| mrf_we | output | 1 | Main-file write enable |
| mrf_wdata | output | 32 | Main-file write data |

## Verification
The bench targets these corner cases:

- **Same-cycle read and write.** A design without the forwarding path would return the previous value, or report an empty entry.
- **Strand end with a same-cycle result.** A design that let the write win would leave a stale value readable after the strand ended. One that emptied the slot before its reads would flag the ending instruction's own operands.
- **Refused results.** A shared unit writing the last-result file, both upper targets set at once, or an out-of-range index must not leak into any level, and that includes the main-file port.
- **Split and single last-result builds.** Both builds get the same stimulus. Mixing up their indexing would show as wrong data or a missing flag on bank reads.

// File: rtl/ofh_pkg.sv
package ofh_pkg;
  localparam int N_SRC = 3;
  typedef enum logic [1:0] {
    LVL_NONE = 2'd0,
    LVL_MAIN = 2'd1,
    LVL_ORF  = 2'd2,
    LVL_LRF  = 2'd3
  } lvl_e;
endpackage

// File: rtl/ofh_store.sv
module ofh_store #(
  parameter int DW    = 32,
  parameter int SLOTS = 8,
  parameter int PER   = 3,
  parameter int NRD   = 3,
  parameter int IW    = 2,
  localparam int SW   = $clog2(SLOTS),
  localparam int E    = SLOTS * PER,
  localparam int EW   = (E > 1) ? $clog2(E) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SW-1:0]     wslot,
  input  logic [IW-1:0]     widx,
  input  logic [DW-1:0]     wdata,
  input  logic              inv,
  input  logic [SW-1:0]     islot,
  input  logic [SW-1:0]     rd_slot,
  input  logic [NRD*IW-1:0] rd_idx,
  output logic [NRD*DW-1:0] rd_data,
  output logic [NRD-1:0]    rd_hit
);
  logic [E-1:0]  valid_q, valid_d;
  logic [DW-1:0] data_q [E];
  logic          wr_ok;
  logic [EW-1:0] wsel;

  assign wr_ok = we && (int'(widx) < PER);
  assign wsel  = EW'(int'(wslot) * PER + (wr_ok ? int'(widx) : 0));

  always_comb begin
    valid_d = valid_q;
    if (wr_ok) valid_d[wsel] = 1'b1;
    if (inv) begin
      for (int p = 0; p < PER; p++) valid_d[int'(islot) * PER + p] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_ok) data_q[wsel] <= wdata;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [IW-1:0] idx;
    logic          idx_ok, byp;
    logic [EW-1:0] sel;
    always_comb begin
      idx     = rd_idx[r*IW +: IW];
      idx_ok  = int'(idx) < PER;
      sel     = EW'(int'(rd_slot) * PER + (idx_ok ? int'(idx) : 0));
      byp     = wr_ok && idx_ok && (wslot == rd_slot) && (widx == idx);
      rd_hit[r]           = idx_ok && (byp || valid_q[sel]);
      rd_data[r*DW +: DW] = byp ? wdata : data_q[sel];
    end
  end

  function automatic int slot_live(input logic [E-1:0] v, input logic [SW-1:0] s);
    int n = 0;
    for (int p = 0; p < PER; p++) n += int'(v[int'(s) * PER + p]);
    return n;
  endfunction

  AST_INV_EMPTIES_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    inv |=> (slot_live(valid_q, $past(islot)) == 0)); // R8

  AST_WRITE_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && !(inv && (islot == wslot))) |=> valid_q[$past(wsel)]); // R3
endmodule

// File: rtl/ofh_rules.sv
module ofh_rules
  import ofh_pkg::*;
#(
  parameter int ORF_PER   = 3,
  parameter int LRF_BANKS = 1,
  parameter bit SPLIT     = 1'b0,
  parameter int IW        = 2
) (
  input  logic                issue_shared,
  input  logic [N_SRC*2-1:0]  src_lvl,
  input  logic [N_SRC*IW-1:0] src_idx,
  input  logic                wb_shared,
  input  logic                wb_orf,
  input  logic                wb_lrf,
  input  logic [IW-1:0]       wb_idx,
  output logic [N_SRC-1:0]    rd_ok,
  output logic                wb_ok
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    lvl_e          lvl;
    logic [IW-1:0] idx;
    always_comb begin
      lvl      = lvl_e'(src_lvl[2*i +: 2]);
      idx      = src_idx[i*IW +: IW];
      rd_ok[i] = 1'b1;
      unique case (lvl)
        LVL_ORF: rd_ok[i] = int'(idx) < ORF_PER;
        LVL_LRF: rd_ok[i] = !issue_shared && (!SPLIT || (int'(idx) < LRF_BANKS));
        default: rd_ok[i] = 1'b1;
      endcase
    end
  end

  always_comb begin
    wb_ok = 1'b1;
    if (wb_orf && wb_lrf)                                wb_ok = 1'b0;
    if (wb_lrf && wb_shared)                             wb_ok = 1'b0;
    if (wb_orf && (int'(wb_idx) >= ORF_PER))             wb_ok = 1'b0;
    if (wb_lrf && SPLIT && (int'(wb_idx) >= LRF_BANKS))  wb_ok = 1'b0;
  end
endmodule

// File: rtl/ofh_lane_opfile.sv
module ofh_lane_opfile
  import ofh_pkg::*;
#(
  parameter int DW        = 32,
  parameter int SLOTS     = 8,
  parameter int ORF_PER   = 3,
  parameter int IW        = 2,
  parameter bit SPLIT_LRF = 1'b0,
  localparam int SW        = $clog2(SLOTS),
  localparam int LRF_BANKS = SPLIT_LRF ? N_SRC : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                issue_valid,
  input  logic [SW-1:0]       issue_slot,
  input  logic                issue_shared,
  input  logic                issue_strand_end,
  input  logic [N_SRC*2-1:0]  src_lvl,
  input  logic [N_SRC*IW-1:0] src_idx,
  input  logic [N_SRC*DW-1:0] mrf_rdata,
  input  logic                wb_valid,
  input  logic [SW-1:0]       wb_slot,
  input  logic                wb_shared,
  input  logic                wb_to_mrf,
  input  logic                wb_orf,
  input  logic                wb_lrf,
  input  logic [IW-1:0]       wb_idx,
  input  logic [DW-1:0]       wb_data,
  output logic                opnd_valid,
  output logic [N_SRC*DW-1:0] opnd_data,
  output logic [N_SRC-1:0]    opnd_err,
  output logic                wb_err,
  output logic                mrf_we,
  output logic [DW-1:0]       mrf_wdata
);
  logic [N_SRC-1:0]    rd_ok;
  logic                wb_ok;
  logic                orf_we, lrf_we, inv;
  logic [IW-1:0]       lrf_widx;
  logic [N_SRC*IW-1:0] lrf_ridx;
  logic [N_SRC*DW-1:0] orf_rdata, lrf_rdata;
  logic [N_SRC-1:0]    orf_hit, lrf_hit;
  logic [N_SRC*DW-1:0] data_d, data_q;
  logic [N_SRC-1:0]    err_d, err_q;
  logic                valid_q, wberr_d, wberr_q;

  ofh_rules #(.ORF_PER(ORF_PER), .LRF_BANKS(LRF_BANKS), .SPLIT(SPLIT_LRF), .IW(IW)) u_rules (
    .issue_shared (issue_shared),
    .src_lvl      (src_lvl),
    .src_idx      (src_idx),
    .wb_shared    (wb_shared),
    .wb_orf       (wb_orf),
    .wb_lrf       (wb_lrf),
    .wb_idx       (wb_idx),
    .rd_ok        (rd_ok),
    .wb_ok        (wb_ok)
  );

  assign orf_we    = wb_valid && wb_ok && wb_orf;
  assign lrf_we    = wb_valid && wb_ok && wb_lrf;
  assign inv       = issue_valid && issue_strand_end;
  assign mrf_we    = wb_valid && wb_ok && wb_to_mrf;
  assign mrf_wdata = wb_data;

  if (SPLIT_LRF) begin : g_split
    assign lrf_widx = wb_idx;
    assign lrf_ridx = src_idx;
  end else begin : g_single
    assign lrf_widx = '0;
    assign lrf_ridx = '0;
  end

  ofh_store #(.DW(DW), .SLOTS(SLOTS), .PER(ORF_PER), .NRD(N_SRC), .IW(IW)) u_orf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (orf_we),
    .wslot   (wb_slot),
    .widx    (wb_idx),
    .wdata   (wb_data),
    .inv     (inv),
    .islot   (issue_slot),
    .rd_slot (issue_slot),
    .rd_idx  (src_idx),
    .rd_data (orf_rdata),
    .rd_hit  (orf_hit)
  );

  ofh_store #(.DW(DW), .SLOTS(SLOTS), .PER(LRF_BANKS), .NRD(N_SRC), .IW(IW)) u_lrf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (lrf_we),
    .wslot   (wb_slot),
    .widx    (lrf_widx),
    .wdata   (wb_data),
    .inv     (inv),
    .islot   (issue_slot),
    .rd_slot (issue_slot),
    .rd_idx  (lrf_ridx),
    .rd_data (lrf_rdata),
    .rd_hit  (lrf_hit)
  );

  for (genvar i = 0; i < N_SRC; i++) begin : g_sel
    lvl_e lvl;
    always_comb begin
      lvl                = lvl_e'(src_lvl[2*i +: 2]);
      data_d[i*DW +: DW] = '0;
      err_d[i]           = 1'b0;
      if (issue_valid) begin
        unique case (lvl)
          LVL_MAIN: data_d[i*DW +: DW] = mrf_rdata[i*DW +: DW];
          LVL_ORF: begin
            if (rd_ok[i] && orf_hit[i]) data_d[i*DW +: DW] = orf_rdata[i*DW +: DW];
            else                        err_d[i] = 1'b1;
          end
          LVL_LRF: begin
            if (rd_ok[i] && lrf_hit[i]) data_d[i*DW +: DW] = lrf_rdata[i*DW +: DW];
            else                        err_d[i] = 1'b1;
          end
          default: data_d[i*DW +: DW] = '0;
        endcase
      end
    end
  end

  assign wberr_d = wb_valid && !wb_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= '0;
      wberr_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= issue_valid;
      err_q   <= err_d;
      wberr_q <= wberr_d;
      data_q  <= data_d;
    end
  end

  assign opnd_valid = valid_q;
  assign opnd_data  = data_q;
  assign opnd_err   = err_q;
  assign wb_err     = wberr_q;

  AST_OPND_FOLLOWS_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |=> opnd_valid); // R2

  AST_DUAL_UPPER_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_orf && wb_lrf) |=> wb_err); // R6

  AST_DUAL_UPPER_NO_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_orf && wb_lrf) |-> !mrf_we); // R6

  AST_SHARED_LRF_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_shared && wb_lrf) |=> wb_err); // R7
endmodule

// File: tb/ofh_lane_opfile_bench.sv
`timescale 1ns/100ps
module ofh_lane_opfile_bench;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic        issue_valid, issue_shared, issue_strand_end;
  logic [2:0]  issue_slot;
  logic [5:0]  src_lvl, src_idx;
  logic [95:0] mrf_rdata;
  logic        wb_valid, wb_shared, wb_to_mrf, wb_orf, wb_lrf;
  logic [2:0]  wb_slot;
  logic [1:0]  wb_idx;
  logic [31:0] wb_data;

  logic        ov   [2];
  logic [95:0] od   [2];
  logic [2:0]  oe   [2];
  logic        owe  [2];
  logic        mwe  [2];
  logic [31:0] mwd  [2];

  int vectors = 0;
  int miscompares = 0;

  ofh_lane_opfile #(.SPLIT_LRF(1'b0)) u_ofh_lane_opfile (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_slot(issue_slot),
    .issue_shared(issue_shared), .issue_strand_end(issue_strand_end),
    .src_lvl(src_lvl), .src_idx(src_idx), .mrf_rdata(mrf_rdata),
    .wb_valid(wb_valid), .wb_slot(wb_slot), .wb_shared(wb_shared), .wb_to_mrf(wb_to_mrf),
    .wb_orf(wb_orf), .wb_lrf(wb_lrf), .wb_idx(wb_idx), .wb_data(wb_data),
    .opnd_valid(ov[0]), .opnd_data(od[0]), .opnd_err(oe[0]), .wb_err(owe[0]),
    .mrf_we(mwe[0]), .mrf_wdata(mwd[0]));

  ofh_lane_opfile #(.SPLIT_LRF(1'b1)) u_ofh_lane_opfile_split (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_slot(issue_slot),
    .issue_shared(issue_shared), .issue_strand_end(issue_strand_end),
    .src_lvl(src_lvl), .src_idx(src_idx), .mrf_rdata(mrf_rdata),
    .wb_valid(wb_valid), .wb_slot(wb_slot), .wb_shared(wb_shared), .wb_to_mrf(wb_to_mrf),
    .wb_orf(wb_orf), .wb_lrf(wb_lrf), .wb_idx(wb_idx), .wb_data(wb_data),
    .opnd_valid(ov[1]), .opnd_data(od[1]), .opnd_err(oe[1]), .wb_err(owe[1]),
    .mrf_we(mwe[1]), .mrf_wdata(mwd[1]));

  // behavioural reference: k=0 single last-result entry, k=1 split banks
  logic [31:0] m_orf  [2][8][3];
  bit          m_orfv [2][8][3];
  logic [31:0] m_lrf  [2][8][3];
  bit          m_lrfv [2][8][3];

  task automatic chk(input string tag, input string what, input int k,
                     input logic [95:0] act, input logic [95:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s inst%0d actual %h expected %h", tag, what, k, act, exp);
    end
  endtask

  function automatic bit m_wb_ok(input int k);
    if (wb_orf && wb_lrf) return 1'b0;
    if (wb_lrf && wb_shared) return 1'b0;
    if (wb_orf && wb_idx == 2'd3) return 1'b0;
    if (wb_lrf && k == 1 && wb_idx == 2'd3) return 1'b0;
    return 1'b1;
  endfunction

  task automatic m_read(input int k, input int i, output logic [31:0] d, output bit e);
    int lvl = int'(src_lvl[2*i +: 2]);
    int idx = int'(src_idx[2*i +: 2]);
    int s   = int'(issue_slot);
    bit wok = wb_valid && m_wb_ok(k);
    int b;
    d = '0; e = 1'b0;
    if (!issue_valid) return;
    if (lvl == 1) d = mrf_rdata[32*i +: 32];
    else if (lvl == 2) begin
      if (idx == 3) e = 1'b1;
      else if (wok && wb_orf && int'(wb_slot) == s && int'(wb_idx) == idx) d = wb_data;
      else if (m_orfv[k][s][idx]) d = m_orf[k][s][idx];
      else e = 1'b1;
    end else if (lvl == 3) begin
      b = (k == 1) ? idx : 0;
      if (issue_shared || b == 3) e = 1'b1;
      else if (wok && wb_lrf && int'(wb_slot) == s && ((k == 1) ? int'(wb_idx) : 0) == b) d = wb_data;
      else if (m_lrfv[k][s][b]) d = m_lrf[k][s][b];
      else e = 1'b1;
    end
  endtask

  task automatic step(input string tag);
    logic [95:0] ed [2];
    logic [2:0]  ee [2];
    bit          ew [2];
    logic [31:0] d;
    bit          e;
    for (int k = 0; k < 2; k++) begin
      ed[k] = '0; ee[k] = '0;
      for (int i = 0; i < 3; i++) begin
        m_read(k, i, d, e);
        ed[k][32*i +: 32] = d;
        ee[k][i] = e;
      end
      ew[k] = wb_valid && !m_wb_ok(k);
    end
    #1;
    for (int k = 0; k < 2; k++) begin
      chk(tag, "mrf_we", k, 96'(mwe[k]), 96'(wb_valid && m_wb_ok(k) && wb_to_mrf));
      if (mwe[k]) chk(tag, "mrf_wdata", k, 96'(mwd[k]), 96'(wb_data));
    end
    for (int k = 0; k < 2; k++) begin
      if (wb_valid && m_wb_ok(k)) begin
        if (wb_orf) begin
          m_orf[k][wb_slot][wb_idx] = wb_data; m_orfv[k][wb_slot][wb_idx] = 1'b1;
        end
        if (wb_lrf) begin
          m_lrf[k][wb_slot][(k == 1) ? int'(wb_idx) : 0] = wb_data;
          m_lrfv[k][wb_slot][(k == 1) ? int'(wb_idx) : 0] = 1'b1;
        end
      end
      if (issue_valid && issue_strand_end)
        for (int p = 0; p < 3; p++) begin
          m_orfv[k][issue_slot][p] = 1'b0; m_lrfv[k][issue_slot][p] = 1'b0;
        end
    end
    @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(tag, "opnd_valid", k, 96'(ov[k]), 96'(issue_valid));
      chk(tag, "opnd_data", k, od[k], ed[k]);
      chk(tag, "opnd_err", k, 96'(oe[k]), 96'(ee[k]));
      chk(tag, "wb_err", k, 96'(owe[k]), 96'(ew[k]));
    end
  endtask

  task automatic idle();
    issue_valid = 0; issue_shared = 0; issue_strand_end = 0; issue_slot = 0;
    src_lvl = 0; src_idx = 0; mrf_rdata = 0;
    wb_valid = 0; wb_shared = 0; wb_to_mrf = 0; wb_orf = 0; wb_lrf = 0;
    wb_slot = 0; wb_idx = 0; wb_data = 0;
  endtask

  task automatic src(input int i, input int lvl, input int idx);
    src_lvl[2*i +: 2] = 2'(lvl);
    src_idx[2*i +: 2] = 2'(idx);
  endtask

  task automatic wb(input int slot, input int idx, input bit orf, input bit lrf,
                    input bit main, input logic [31:0] d);
    wb_valid = 1; wb_slot = 3'(slot); wb_idx = 2'(idx);
    wb_orf = orf; wb_lrf = lrf; wb_to_mrf = main; wb_data = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int k = 0; k < 2; k++)
      for (int s = 0; s < 8; s++)
        for (int p = 0; p < 3; p++) begin
          m_orfv[k][s][p] = 0; m_lrfv[k][s][p] = 0; m_orf[k][s][p] = 0; m_lrf[k][s][p] = 0;
        end
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk("R1", "reset opnd_valid", k, 96'(ov[k]), 96'd0);
      chk("R1", "reset opnd_err", k, 96'(oe[k]), 96'd0);
      chk("R1", "reset wb_err", k, 96'(owe[k]), 96'd0);
    end
    // R1: upper levels empty after reset
    issue_valid = 1; src(0, 2, 0); src(1, 3, 0); src(2, 2, 2);
    step("R1");
    // R5: result to main and operand file together
    idle(); wb(0, 0, 1, 0, 1, 32'hA5A5_0001);
    step("R5");
    // R10: same-cycle forward from last-result write; R2 main slice
    idle(); wb(0, 0, 0, 1, 0, 32'hB2B2_0002);
    issue_valid = 1; src(0, 2, 0); src(1, 3, 0); src(2, 1, 0);
    mrf_rdata = {32'hC3C3_0003, 32'h1111_1111, 32'h2222_2222};
    step("R10");
    // R3: slots separate
    idle(); wb(1, 2, 1, 0, 0, 32'hD4D4_0004);
    issue_valid = 1; src(0, 2, 2); src(1, 2, 0);
    step("R3");
    idle(); issue_valid = 1; issue_slot = 1; src(0, 2, 2); src(1, 2, 0);
    step("R3");
    // R4: index ignored in single build (split build: empty bank 2)
    idle(); issue_valid = 1; src(0, 3, 2); src(1, 3, 1);
    step("R4");
    // R12: split banks selected by index
    idle(); wb(0, 1, 0, 1, 0, 32'hE5E5_0005);
    step("R12");
    idle(); issue_valid = 1; src(0, 3, 0); src(1, 3, 1); src(2, 3, 3);
    step("R12");
    // R6: both upper targets
    idle(); wb(0, 1, 1, 1, 1, 32'hFFFF_0006);
    step("R6");
    idle(); issue_valid = 1; src(0, 2, 1);
    step("R6");
    // R7: shared units and the last-result file
    idle(); issue_valid = 1; issue_shared = 1; src(0, 3, 0); src(1, 2, 0); src(2, 1, 0);
    mrf_rdata = 96'h7;
    wb(0, 0, 0, 1, 1, 32'h5151_0007); wb_shared = 1;
    step("R7");
    idle(); wb(0, 1, 1, 0, 0, 32'h7777_0008); wb_shared = 1;
    step("R7");
    idle(); issue_valid = 1; issue_shared = 1; src(0, 2, 1);
    step("R7");
    // R11: operand file index 3
    idle(); wb(0, 3, 1, 0, 1, 32'h3333_0009);
    issue_valid = 1; src(0, 2, 3);
    step("R11");
    // R8: strand end: old reads, same-cycle write dropped, other slot intact
    idle(); issue_valid = 1; issue_strand_end = 1; src(0, 2, 0); src(1, 3, 0);
    wb(0, 2, 1, 0, 0, 32'h9999_000A);
    step("R8");
    idle(); issue_valid = 1; src(0, 2, 2); src(1, 2, 0); src(2, 3, 0);
    step("R8");
    idle(); issue_valid = 1; issue_slot = 1; src(0, 2, 2);
    step("R8");
    // R9: empty entries flagged per source
    idle(); issue_valid = 1; issue_slot = 5; src(0, 1, 0); src(1, 2, 1); src(2, 3, 0);
    mrf_rdata = 96'hABCD;
    step("R9");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      issue_valid      = ($urandom % 4) != 0;
      issue_slot       = 3'($urandom % 3);
      issue_shared     = ($urandom % 4) == 0;
      issue_strand_end = ($urandom % 16) == 0;
      src_lvl          = 6'($urandom);
      src_idx          = 6'($urandom);
      mrf_rdata        = {$urandom, $urandom, $urandom};
      wb_valid         = ($urandom % 4) != 0;
      wb_slot          = 3'($urandom % 3);
      wb_shared        = ($urandom % 4) == 0;
      wb_to_mrf        = 1'($urandom);
      wb_orf           = 1'($urandom);
      wb_lrf           = ($urandom % 3) == 0;
      wb_idx           = 2'($urandom);
      wb_data          = $urandom;
      step("R2");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule